// File: doc/BRIEF.md
# Split or Unified Match Comparator

This block holds a bank of match registers and compares them against a timer count that is either two separate 16-bit halves (low and high) or a single 32-bit value made by joining those halves. Each register has a low part and a high part. The result is two registered match vectors, one bit per register for each half. A match bit pulses for one cycle in every clock where equality holds and the counter being compared is running.

A mode input selects the comparison. In split mode the low parts are compared only with the low count, and the high parts only with the high count. Each half uses its own stop and halt controls. In unified mode each register's high and low parts form one 32-bit value, which is compared with the joined count. The low-half stop and halt controls then gate the result, and both output vectors carry the same unified result.

Match values are loaded through a write port with a per-half select. A half may only be written while its counter is halted. A write to a running half is dropped and flagged as a bus error for that half. The other half of the same word can still be written.

Top module: `split_match_cmp`

## Requirements
- R1: During reset all match registers clear to 0 and match_lo, match_hi, buserr_lo and buserr_hi are 0.
- R2: With unify=0, match_lo[i] is 1 in the cycle after a clock edge at which the low part of register i equals cnt_lo and both stop_lo and halt_lo are 0.
- R3: With unify=0, match_hi[i] depends only on the high part of register i, cnt_hi, stop_hi and halt_hi; the low-half inputs do not affect it.
- R4: With unify=1, register i matches when {high part, low part} equals {cnt_hi, cnt_lo}, and match_lo and match_hi are then identical.
- R5: In split mode, either stop or halt of a half at 1 forces that half's match vector to 0 on the next cycle, while the other half keeps matching.
- R6: With unify=1, the run condition uses only stop_lo and halt_lo; stop_hi and halt_hi have no effect on the outputs.
- R7: Outputs are registered with one cycle of latency, and a match bit stays high for every consecutive cycle in which equality and the run condition hold.
- R8: wr_half bit 0 selects the low 16 bits of wr_data and bit 1 the high 16 bits. The selected halves are written to register wr_idx at the clock edge, but only when the governing halt is 1. With no write, the registers keep their values.
- R9: A selected half whose governing halt is 0 is not written, and that half's bus error output (buserr_lo or buserr_hi) pulses on the next cycle. The other half of the same write is unaffected.
- R10: In split mode the low half is governed by halt_lo and the high half by halt_hi. In unified mode both halves are governed by halt_lo.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unify | input | 1 | 1 = one 32-bit comparison, 0 = two 16-bit comparisons |
| stop_lo | input | 1 | Low/unified counter stopped |
| halt_lo | input | 1 | Low/unified counter halted |
| stop_hi | input | 1 | High counter stopped |
| halt_hi | input | 1 | High counter halted |
| cnt_lo | input | 16 | Low counter value |
| cnt_hi | input | 16 | High counter value |
| wr_en | input | 1 | Match register write strobe |
| wr_idx | input | 3 | Register number to write |
| wr_half | input | 2 | Half select: bit 0 low, bit 1 high |
| wr_data | input | 32 | Write data, high half in bits 31:16 |
| match_lo | output | 8 | Registered per-register low/unified match pulses |
| match_hi | output | 8 | Registered per-register high/unified match pulses |
| buserr_lo | output | 1 | Rejected low-half write, one-cycle pulse |
| buserr_hi | output | 1 | Rejected high-half write, one-cycle pulse |

## Verification
The bench first loads a register with different low and high values. It then sets counts where only the low half equals, only the high half equals, or both equal, in both modes. This separates independent 16-bit matching from the 32-bit concatenated comparison. Stop and halt are toggled one half at a time to show which half's controls gate each mode. Writes are issued with one half running and the other halted, so the bench can tell per-half rejection from whole-word rejection. Random traffic then draws counts from the stored values so that real matches occur often.

// File: rtl/mc_pkg.sv
package mc_pkg;
    typedef enum logic {
        MODE_SPLIT   = 1'b0,
        MODE_UNIFIED = 1'b1
    } cmp_mode_e;

    typedef struct packed {
        logic stop;
        logic halt;
    } half_ctl_t;

    localparam int HALF_LO = 0;
    localparam int HALF_HI = 1;
endpackage

// File: rtl/match_reg_bank.sv
module match_reg_bank
    import mc_pkg::*;
#(
    parameter int NUM_MATCH = 8,
    parameter int HALF_W    = 16,
    localparam int IDX_W    = $clog2(NUM_MATCH)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  cmp_mode_e                         mode,
    input  half_ctl_t                         ctl_lo,
    input  half_ctl_t                         ctl_hi,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [1:0]                        wr_half,
    input  logic [2*HALF_W-1:0]               wr_data,
    output logic [NUM_MATCH-1:0][HALF_W-1:0]  val_lo,
    output logic [NUM_MATCH-1:0][HALF_W-1:0]  val_hi,
    output logic                              err_lo,
    output logic                              err_hi
);
    logic ok_lo, ok_hi;

    // Governing halt for each half
    always_comb begin
        ok_lo = ctl_lo.halt;
        unique case (mode)
            MODE_SPLIT:   ok_hi = ctl_hi.halt;
            MODE_UNIFIED: ok_hi = ctl_lo.halt;
            default:      ok_hi = 1'b0;
        endcase
    end

    for (genvar g = 0; g < NUM_MATCH; g++) begin : g_entry
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_lo[g] <= '0;
                val_hi[g] <= '0;
            end else begin
                if (hit && wr_half[HALF_LO] && ok_lo)
                    val_lo[g] <= wr_data[HALF_W-1:0];
                if (hit && wr_half[HALF_HI] && ok_hi)
                    val_hi[g] <= wr_data[2*HALF_W-1:HALF_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_lo <= 1'b0;
            err_hi <= 1'b0;
        end else begin
            err_lo <= wr_en && wr_half[HALF_LO] && !ok_lo;
            err_hi <= wr_en && wr_half[HALF_HI] && !ok_hi;
        end
    end

    // R8
    hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(val_lo) && $stable(val_hi)));

    // R9
    reject_low_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_half[HALF_LO] && !ctl_lo.halt) |=> err_lo);

    // R10
    unified_hi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_half[HALF_HI] && mode == MODE_UNIFIED && !ctl_lo.halt)
            |=> (err_hi && $stable(val_hi)));
endmodule

// File: rtl/match_compare.sv
module match_compare
    import mc_pkg::*;
#(
    parameter int NUM_MATCH = 8,
    parameter int HALF_W    = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  cmp_mode_e                         mode,
    input  half_ctl_t                         ctl_lo,
    input  half_ctl_t                         ctl_hi,
    input  logic [HALF_W-1:0]                 cnt_lo,
    input  logic [HALF_W-1:0]                 cnt_hi,
    input  logic [NUM_MATCH-1:0][HALF_W-1:0]  val_lo,
    input  logic [NUM_MATCH-1:0][HALF_W-1:0]  val_hi,
    output logic [NUM_MATCH-1:0]              hit_lo,
    output logic [NUM_MATCH-1:0]              hit_hi
);
    logic                 run_lo, run_hi;
    logic [NUM_MATCH-1:0] eq_lo, eq_hi;
    logic [NUM_MATCH-1:0] nxt_lo, nxt_hi;

    assign run_lo = !ctl_lo.stop && !ctl_lo.halt;
    assign run_hi = !ctl_hi.stop && !ctl_hi.halt;

    for (genvar g = 0; g < NUM_MATCH; g++) begin : g_cmp
        assign eq_lo[g] = (val_lo[g] == cnt_lo);
        assign eq_hi[g] = (val_hi[g] == cnt_hi);
    end

    always_comb begin
        unique case (mode)
            MODE_SPLIT: begin
                nxt_lo = run_lo ? eq_lo : '0;
                nxt_hi = run_hi ? eq_hi : '0;
            end
            MODE_UNIFIED: begin
                nxt_lo = run_lo ? (eq_lo & eq_hi) : '0;
                nxt_hi = nxt_lo;
            end
            default: begin
                nxt_lo = '0;
                nxt_hi = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_lo <= '0;
            hit_hi <= '0;
        end else begin
            hit_lo <= nxt_lo;
            hit_hi <= nxt_hi;
        end
    end

    // R4
    unified_equal_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UNIFIED) |=> (hit_lo == hit_hi));

    // R5
    split_lo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SPLIT && (ctl_lo.stop || ctl_lo.halt)) |=> (hit_lo == '0));

    // R5
    split_hi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SPLIT && (ctl_hi.stop || ctl_hi.halt)) |=> (hit_hi == '0));

    // R6
    unified_lo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UNIFIED && (ctl_lo.stop || ctl_lo.halt)) |=> (hit_hi == '0));
endmodule

// File: rtl/split_match_cmp.sv
module split_match_cmp
    import mc_pkg::*;
#(
    parameter int NUM_MATCH = 8,
    parameter int HALF_W    = 16,
    localparam int IDX_W    = $clog2(NUM_MATCH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  unify,
    input  logic                  stop_lo,
    input  logic                  halt_lo,
    input  logic                  stop_hi,
    input  logic                  halt_hi,
    input  logic [HALF_W-1:0]     cnt_lo,
    input  logic [HALF_W-1:0]     cnt_hi,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [1:0]            wr_half,
    input  logic [2*HALF_W-1:0]   wr_data,
    output logic [NUM_MATCH-1:0]  match_lo,
    output logic [NUM_MATCH-1:0]  match_hi,
    output logic                  buserr_lo,
    output logic                  buserr_hi
);
    cmp_mode_e mode;
    half_ctl_t ctl_lo, ctl_hi;
    logic [NUM_MATCH-1:0][HALF_W-1:0] val_lo, val_hi;

    assign mode   = unify ? MODE_UNIFIED : MODE_SPLIT;
    assign ctl_lo = '{stop: stop_lo, halt: halt_lo};
    assign ctl_hi = '{stop: stop_hi, halt: halt_hi};

    match_reg_bank #(.NUM_MATCH(NUM_MATCH), .HALF_W(HALF_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .mode(mode), .ctl_lo(ctl_lo), .ctl_hi(ctl_hi),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_half(wr_half), .wr_data(wr_data),
        .val_lo(val_lo), .val_hi(val_hi), .err_lo(buserr_lo), .err_hi(buserr_hi)
    );

    match_compare #(.NUM_MATCH(NUM_MATCH), .HALF_W(HALF_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .mode(mode), .ctl_lo(ctl_lo), .ctl_hi(ctl_hi),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .val_lo(val_lo), .val_hi(val_hi),
        .hit_lo(match_lo), .hit_hi(match_hi)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (match_lo == '0 && match_hi == '0 && !buserr_lo && !buserr_hi));
endmodule

// File: tb/sim_split_match_cmp.sv
module sim_split_match_cmp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        unify = 1'b0, stop_lo = 1'b0, halt_lo = 1'b0, stop_hi = 1'b0, halt_hi = 1'b0;
    logic [15:0] cnt_lo = '0, cnt_hi = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [1:0]  wr_half = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  match_lo, match_hi;
    logic        buserr_lo, buserr_hi;

    int compared = 0, mismatched = 0, cycles = 0;
    bit done = 0;
    logic [15:0] m_lo [8];
    logic [15:0] m_hi [8];

    always #10 clk = ~clk;

    split_match_cmp u0 (.*);

    function automatic logic [17:0] expect_out();
        logic [7:0] el, eh;
        logic rl, rh;
        logic okl, okh;
        rl = !stop_lo && !halt_lo;
        rh = !stop_hi && !halt_hi;
        for (int i = 0; i < 8; i++) begin
            if (unify) begin
                el[i] = rl && (m_lo[i] == cnt_lo) && (m_hi[i] == cnt_hi);
                eh[i] = el[i];
            end else begin
                el[i] = rl && (m_lo[i] == cnt_lo);
                eh[i] = rh && (m_hi[i] == cnt_hi);
            end
        end
        okl = halt_lo;
        okh = unify ? halt_lo : halt_hi;
        return {el, eh, wr_en && wr_half[0] && !okl, wr_en && wr_half[1] && !okh};
    endfunction

    task automatic check(string tag, logic [17:0] got, logic [17:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got lo=%h hi=%h el=%b eh=%b, expected lo=%h hi=%h el=%b eh=%b",
                     tag, got[17:10], got[9:2], got[1], got[0],
                     exp[17:10], exp[9:2], exp[1], exp[0]);
        end
    endtask

    task automatic step(string tag);
        logic [17:0] e;
        e = expect_out();
        @(posedge clk);
        if (wr_en) begin
            if (wr_half[0] && halt_lo) m_lo[wr_idx] = wr_data[15:0];
            if (wr_half[1] && (unify ? halt_lo : halt_hi)) m_hi[wr_idx] = wr_data[31:16];
        end
        @(negedge clk);
        check(tag, {match_lo, match_hi, buserr_lo, buserr_hi}, e);
    endtask

    task automatic set_run(bit u, bit sl, bit hl, bit sh, bit hh);
        unify = u; stop_lo = sl; halt_lo = hl; stop_hi = sh; halt_hi = hh;
    endtask

    task automatic wr(bit e, logic [2:0] idx, logic [1:0] hf, logic [31:0] d);
        wr_en = e; wr_idx = idx; wr_half = hf; wr_data = d;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset", {match_lo, match_hi, buserr_lo, buserr_hi}, '0);
        rst_n = 1'b1;
        // R1: registers cleared, so count 0 matches every register
        step("R1 zero match");
        // R8: load register 3 while both halves halted
        set_run(0, 0, 1, 0, 1);
        wr(1, 3'd3, 2'b11, 32'h0005_0009);
        step("R8 write");
        wr(0, 0, 0, 0);
        set_run(0, 0, 0, 0, 0);
        cnt_lo = 16'd9; cnt_hi = 16'd5;
        step("R2 split both");
        step("R7 held");
        cnt_hi = 16'd6;
        step("R3 lo only");
        cnt_lo = 16'd8; cnt_hi = 16'd5;
        step("R3 hi only");
        // R4 unified
        unify = 1; cnt_lo = 16'd9; cnt_hi = 16'd5;
        step("R4 unified hit");
        cnt_hi = 16'd6;
        step("R4 unified miss hi");
        cnt_hi = 16'd5; stop_hi = 1; halt_hi = 1;
        step("R6 hi ctl ignored");
        stop_lo = 1;
        step("R6 lo stop gates");
        // R5 split suppression
        set_run(0, 1, 0, 0, 0);
        step("R5 lo stopped");
        set_run(0, 0, 0, 0, 1);
        step("R5 hi halted");
        // R9 partial write: low running, high halted
        set_run(0, 0, 0, 0, 1);
        wr(1, 3'd6, 2'b11, 32'h0077_0033);
        step("R9 partial");
        wr(0, 0, 0, 0);
        set_run(0, 0, 0, 0, 0);
        cnt_lo = 16'd0; cnt_hi = 16'h77;
        step("R9 hi took lo kept");
        // R10 unified: high half governed by low halt
        set_run(1, 0, 0, 0, 1);
        wr(1, 3'd2, 2'b10, 32'hABCD_0000);
        step("R10 reject hi");
        set_run(1, 0, 1, 0, 0);
        wr(1, 3'd2, 2'b11, 32'h1234_5678);
        step("R10 accept both");
        wr(0, 0, 0, 0);
        set_run(1, 0, 0, 0, 0);
        cnt_lo = 16'h5678; cnt_hi = 16'h1234;
        step("R10 unified readback");
        // Random mix
        for (int n = 0; n < 400; n++) begin
            int k;
            k = $urandom_range(7);
            set_run($urandom_range(1), $urandom_range(3) == 0, $urandom_range(2) == 0,
                    $urandom_range(3) == 0, $urandom_range(2) == 0);
            if ($urandom_range(3) == 0)
                wr(1, 3'($urandom_range(7)), 2'($urandom_range(3)),
                   {16'($urandom_range(3)), 16'($urandom_range(3))});
            else
                wr(0, 0, 0, 0);
            cnt_lo = ($urandom_range(1) != 0) ? m_lo[k] : 16'($urandom_range(3));
            cnt_hi = ($urandom_range(1) != 0) ? m_hi[k] : 16'($urandom_range(3));
            step("RND R7");
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule